// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block resolves data hazards for a four-stage in-order pipeline whose stages are fetch, register read, ALU and write-back. It sits beside the register-read stage. It looks at the two source register numbers of the instruction being read and compares them with the destination numbers of the two older instructions in the ALU and write-back stages. For each source, it picks the freshest available value: the ALU-stage result, the write-back-stage result, or the register file output.

A load in the ALU stage has no data yet, because memory returns it only in the load's write-back cycle. The block therefore never forwards a load's ALU-stage value. When the next instruction needs that register, the block raises a stall that freezes fetch and register read. It also raises a bubble request that puts a NOP into the ALU stage. One cycle later the load reaches write-back and the ordinary write-back path serves the consumer. The block is purely combinational and has no state.

Top module: `operand_bypass`

## Requirements
- R1: A source index of 31 (all ones in the 5-bit index) reads as zero on that operand whatever the stages hold, and never causes a stall.
- R2: When neither the ALU stage nor the write-back stage matches a source, that operand equals the register file data for it.
- R3: A non-load ALU-stage instruction with write enable 1 whose destination equals a source supplies its result to that operand.
- R4: A write-back-stage instruction with write enable 1 whose destination equals a source supplies its result when the ALU stage does not.
- R5: When both stages match the same source, the ALU-stage result wins over the write-back result.
- R6: A stage with write enable 0 takes part in neither forwarding nor stalling, even when its destination matches and its load flag is 1.
- R7: A load (load flag 1, write enable 1) in the ALU stage whose destination equals a non-31 source of either operand drives both the stall and the bubble outputs to 1.
- R8: The ALU-stage result of a load is never forwarded. An operand matching such a load takes the write-back value if that stage matches, otherwise the register file value.
- R9: Stall and bubble stay 0 whenever the R7 condition is absent, including when a non-load matches in the ALU stage or a load matches in write-back.
- R10: The two operands are selected independently, each by its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_a_idx | input | 5 | First source register number in register read |
| rs_b_idx | input | 5 | Second source register number in register read |
| rf_a_data | input | 32 | Register file data for the first source |
| rf_b_data | input | 32 | Register file data for the second source |
| ex_dst | input | 5 | Destination register of the ALU-stage instruction |
| ex_wen | input | 1 | ALU-stage instruction writes a register |
| ex_is_load | input | 1 | ALU-stage instruction is a load |
| ex_result | input | 32 | ALU-stage result |
| wb_dst | input | 5 | Destination register of the write-back-stage instruction |
| wb_wen | input | 1 | Write-back-stage instruction writes a register |
| wb_result | input | 32 | Write-back-stage result |
| opnd_a | output | 32 | Selected first operand |
| opnd_b | output | 32 | Selected second operand |
| stall_front | output | 1 | Hold fetch and register read this cycle |
| inject_nop | output | 1 | Load a NOP into the ALU stage |

## Verification
Directed vectors place dependences at distance one and at distance two, with both paths matching at once so the priority is visible. They also cover a load at distance one, which must stall, and a load at distance two, which must forward from write-back. Further vectors set a matching destination with write enable cleared, or use register 31, to show that those cases neither forward nor stall. Random vectors draw indices from a small pool so that the two operands often hit different stages in the same cycle. This separates a shared selection from independent per-operand selection.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs_a_idx,
  input  logic [REG_AW-1:0] rs_b_idx,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [DATA_W-1:0] ex_result,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  input  logic [DATA_W-1:0] wb_result,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              stall_front,
  output logic              inject_nop
);
  localparam logic [REG_AW-1:0] ZERO_REG = {REG_AW{1'b1}};

  logic [1:0] src_live, ex_hit, wb_hit, ld_hit;
  logic [1:0][REG_AW-1:0] src_idx;
  logic [1:0][DATA_W-1:0] rf_data, sel;

  assign src_idx = {rs_b_idx, rs_a_idx};
  assign rf_data = {rf_b_data, rf_a_data};

  for (genvar i = 0; i < 2; i++) begin : g_src
    assign src_live[i] = src_idx[i] != ZERO_REG;
    assign ex_hit[i]   = src_live[i] && ex_wen && ex_dst == src_idx[i];
    assign wb_hit[i]   = src_live[i] && wb_wen && wb_dst == src_idx[i];
    assign ld_hit[i]   = ex_hit[i] && ex_is_load;

    always_comb begin
      if (!src_live[i])                 sel[i] = '0;
      else if (ex_hit[i] && !ex_is_load) sel[i] = ex_result;
      else if (wb_hit[i])               sel[i] = wb_result;
      else                              sel[i] = rf_data[i];
    end
  end

  assign opnd_a      = sel[0];
  assign opnd_b      = sel[1];
  assign stall_front = |ld_hit;
  assign inject_nop  = |ld_hit;
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] rs_a_idx,
  input logic [REG_AW-1:0] rs_b_idx,
  input logic [DATA_W-1:0] rf_a_data,
  input logic [DATA_W-1:0] rf_b_data,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_wen,
  input logic              ex_is_load,
  input logic [DATA_W-1:0] ex_result,
  input logic [REG_AW-1:0] wb_dst,
  input logic              wb_wen,
  input logic [DATA_W-1:0] wb_result,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              stall_front,
  input logic              inject_nop
);
  localparam logic [REG_AW-1:0] ZR = {REG_AW{1'b1}};

  always_comb begin
    p_zero_a_r1: assert (rs_a_idx != ZR || opnd_a == '0);
    p_zero_b_r1: assert (rs_b_idx != ZR || opnd_b == '0);
    p_rf_a_r2: assert (rs_a_idx == ZR || (ex_wen && ex_dst == rs_a_idx) ||
                       (wb_wen && wb_dst == rs_a_idx) || opnd_a == rf_a_data);
    p_rf_b_r2: assert (rs_b_idx == ZR || (ex_wen && ex_dst == rs_b_idx) ||
                       (wb_wen && wb_dst == rs_b_idx) || opnd_b == rf_b_data);
    p_prio_a_r5: assert (!(rs_a_idx != ZR && ex_wen && !ex_is_load && ex_dst == rs_a_idx) ||
                         opnd_a == ex_result);
    p_wb_b_r4: assert (!(rs_b_idx != ZR && wb_wen && wb_dst == rs_b_idx &&
                         !(ex_wen && !ex_is_load && ex_dst == rs_b_idx)) || opnd_b == wb_result);
    p_stall_src_r9: assert (!stall_front || (ex_wen && ex_is_load));
    p_bubble_r7: assert (stall_front == inject_nop);
    p_ld_stall_r7: assert (!(ex_wen && ex_is_load && rs_a_idx != ZR && ex_dst == rs_a_idx) ||
                           stall_front);
  end
endmodule

bind operand_bypass operand_bypass_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) chk_i (.*);

// File: tb/operand_bypass_tb.sv
module operand_bypass_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] Z = 5'd31;

  logic clk = 0, rst_n = 0;
  logic [4:0] rs_a_idx, rs_b_idx, ex_dst, wb_dst;
  logic [31:0] rf_a_data, rf_b_data, ex_result, wb_result, opnd_a, opnd_b;
  logic ex_wen, ex_is_load, wb_wen, stall_front, inject_nop;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_bypass dut_i (.*);

  function automatic logic [31:0] exp_op(input logic [4:0] idx, input logic [31:0] rf);
    if (idx == Z) return '0;
    if (ex_wen && !ex_is_load && ex_dst == idx) return ex_result;
    if (wb_wen && wb_dst == idx) return wb_result;
    return rf;
  endfunction

  function automatic logic exp_stall();
    return ex_wen && ex_is_load &&
           ((rs_a_idx != Z && ex_dst == rs_a_idx) || (rs_b_idx != Z && ex_dst == rs_b_idx));
  endfunction

  task automatic put(input logic [4:0] a, input logic [4:0] b,
                     input logic [4:0] ed, input logic ew, input logic el,
                     input logic [4:0] wd, input logic ww);
    @(posedge clk);
    rs_a_idx = a; rs_b_idx = b; ex_dst = ed; ex_wen = ew; ex_is_load = el;
    wb_dst = wd; wb_wen = ww;
    rf_a_data = 32'hA0A0_0000 | 32'(a); rf_b_data = 32'hB0B0_0000 | 32'(b);
    ex_result = 32'hE000_0E0E; wb_result = 32'h0B0B_5000;
  endtask

  task automatic check(input string tag);
    logic [31:0] ea, eb;
    logic es;
    @(negedge clk);
    ea = exp_op(rs_a_idx, rf_a_data);
    eb = exp_op(rs_b_idx, rf_b_data);
    es = exp_stall();
    checks++;
    if (opnd_a !== ea || opnd_b !== eb || stall_front !== es || inject_nop !== es) begin
      fails++;
      $display("FAIL %s: a=%h/%h b=%h/%h stall=%b/%b nop=%b/%b (actual/expected)",
               tag, opnd_a, ea, opnd_b, eb, stall_front, es, inject_nop, es);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rs_a_idx = 0; rs_b_idx = 0; ex_dst = 0; wb_dst = 0; ex_wen = 0; wb_wen = 0;
    ex_is_load = 0; rf_a_data = 0; rf_b_data = 0; ex_result = 0; wb_result = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    check("reset R2");
    put(3, 4, 9, 1, 0, 10, 1);      check("R2 no match");
    put(3, 4, 3, 1, 0, 10, 1);      check("R3 distance one");
    put(3, 4, 9, 1, 0, 4, 1);       check("R4 distance two");
    put(3, 3, 3, 1, 0, 3, 1);       check("R5 both stages");
    put(3, 4, 3, 0, 1, 4, 0);       check("R6 write enable off");
    put(5, 6, 5, 1, 1, 9, 1);       check("R7 load distance one on A");
    put(7, 6, 6, 1, 1, 9, 0);       check("R7 load distance one on B");
    put(5, 6, 5, 1, 1, 5, 1);       check("R8 load with wb match");
    put(8, 2, 9, 1, 0, 8, 1);       check("R8 load at distance two via wb");
    put(Z, Z, Z, 1, 1, Z, 1);       check("R1 register 31 with load");
    put(Z, 2, Z, 1, 0, 2, 1);       check("R1 register 31 on A");
    put(3, 4, 3, 1, 0, 9, 0);       check("R9 non-load match no stall");
    put(3, 4, 9, 0, 0, 3, 1);       check("R9 wb load match no stall");
    put(3, 4, 3, 1, 0, 4, 1);       check("R10 split stages");
    for (int n = 0; n < 2000; n++) begin
      logic [4:0] pool [4] = '{5'd1, 5'd2, 5'd3, Z};
      @(posedge clk);
      rs_a_idx = pool[$urandom_range(3)]; rs_b_idx = pool[$urandom_range(3)];
      ex_dst = pool[$urandom_range(3)];   wb_dst = pool[$urandom_range(3)];
      ex_wen = 1'($urandom); wb_wen = 1'($urandom); ex_is_load = 1'($urandom);
      rf_a_data = $urandom; rf_b_data = $urandom; ex_result = $urandom; wb_result = $urandom;
      check("R10 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule